// File: doc/BRIEF.md
# Handshake-Capable Parallel Port Block

This block provides two 8-bit parallel ports (A and B) and one 6-bit port C for a small peripheral controller. Each of ports A and B has a direction bit. Port C can serve as plain input lines or as plain output lines. It can also carry handshake control lines for port A alone, or for both A and B. A bus-side block decodes the command fields, supplies single-cycle write and read strobes with a port select and write data, and takes the read data back. The pins arrive as separate input, output and output-enable vectors.

In handshake mode a port runs one of two exchanges, chosen by its direction. In strobed input, a peripheral strobe captures the pin data and marks the buffer full. In strobed output, a processor write marks the buffer full and a peripheral strobe empties it. Each exchange raises an interrupt flag when its interrupt enable is set. The strobe pins are synchronised to the system clock, and each active-low pulse produces one capture or release event at its falling edge and one interrupt event at its rising edge.

Top module: `hsk_ports`

## Requirements
- R1: After synchronous reset, every port is an input (all output enables low), all output latches are zero and all buffer-full and interrupt flags are zero.
- R2: Port select 0 addresses A, 1 addresses B and 2 addresses C. With its direction bit at 1, a port drives its output latch with enable high, a write loads the latch, and a read returns the latch. With its direction bit at 0 and no handshake, a read returns the live pins.
- R3: A port in input mode holds its output latch at zero and ignores writes, so a later switch to output drives all zeros.
- R4: Writing a value equal to the current output latch leaves the output pins unchanged.
- R5: Port C mode codes: 00 makes all six bits plain inputs. 11 makes all six bits plain outputs. 01 makes bits 0-2 port A control and bits 3-5 plain outputs. 10 makes bits 0-2 port A control and bits 3-5 port B control. Output enables follow these assignments, and a read of C returns each bit's driven value for outputs and the pin for inputs.
- R6: Within a control group the lowest bit is the interrupt output, the middle bit is the buffer-full output and the highest bit is the active-low strobe input.
- R7: When a control group becomes enabled, or its port changes direction while enabled, buffer-full starts low. Interrupt starts low for an input port and high for an output port.
- R8: In strobed input, the strobe's falling edge latches the pins and sets buffer-full. Its rising edge sets interrupt if enabled. A read returns the latched data and clears both flags.
- R9: In strobed output, a processor write sets buffer-full and clears interrupt. The strobe's falling edge clears buffer-full and its rising edge sets interrupt if enabled.
- R10: Status bits are, from bit 0: A interrupt, A buffer-full, A interrupt enable, B interrupt, B buffer-full, B interrupt enable. The flags of a disabled group read as 0.
- R11: One strobe pulse produces exactly one capture event and at most one interrupt event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_dir_a | input | 1 | Port A direction, 1 = output |
| cmd_dir_b | input | 1 | Port B direction, 1 = output |
| cmd_pc_mode | input | 2 | Port C mode code |
| cmd_ie_a | input | 1 | Port A interrupt enable |
| cmd_ie_b | input | 1 | Port B interrupt enable |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_sel | input | 2 | Port select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C drive values |
| pc_oe | output | 6 | Port C per-bit output enables |
| stat | output | 6 | Handshake status bits |

## Verification
A vector table walks each port through output readback, ignored writes in input mode and each port C mode. Distinct pin and write patterns tell latch contents apart from live pin levels. It also shows that mixed port C reads merge control flags, strobe pins and latch bits in the right positions. Directed strobe pulses, with the pins changed between the edges, show that capture happens on the falling edge. They also show that interrupt follows the rising edge only when enabled, that a read or write clears the right flags, and that a long pulse yields a single event.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [1:0] {
        PC_ALL_IN  = 2'b00,
        PC_A_CTL   = 2'b01,
        PC_AB_CTL  = 2'b10,
        PC_ALL_OUT = 2'b11
    } pc_mode_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    typedef struct packed {
        logic ie_b;
        logic bf_b;
        logic intr_b;
        logic ie_a;
        logic bf_a;
        logic intr_a;
    } stat_t;

    function automatic logic grp_a_on(input pc_mode_e m);
        return (m == PC_A_CTL) || (m == PC_AB_CTL);
    endfunction

    function automatic logic grp_b_on(input pc_mode_e m);
        return (m == PC_AB_CTL);
    endfunction

    function automatic logic [5:0] pc_oe_map(input pc_mode_e m);
        case (m)
            PC_ALL_IN:  return 6'b000000;
            PC_A_CTL:   return 6'b111011;
            PC_AB_CTL:  return 6'b011011;
            default:    return 6'b111111;
        endcase
    endfunction

endpackage

// File: rtl/hsk_edge_sync.sv
module hsk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[DEPTH-2:0], pin_n};
    end

    assign fall = sh_q[DEPTH-1] & ~sh_q[DEPTH-2];
    assign rise = ~sh_q[DEPTH-1] & sh_q[DEPTH-2];

endmodule

// File: rtl/hsk_port.sv
module hsk_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         dir,
    input  logic         ie,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic         stb_n,
    output logic [W-1:0] out_q,
    output logic [W-1:0] rdata,
    output logic         bf,
    output logic         intr
);
    logic fall, rise;
    logic prev_en, prev_dir, init;
    logic [W-1:0] in_q;

    hsk_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .pin_n(stb_n), .fall(fall), .rise(rise)
    );

    assign init = en && (!prev_en || (prev_dir != dir));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_en  <= 1'b0;
            prev_dir <= 1'b0;
        end else begin
            prev_en  <= en;
            prev_dir <= dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dir) out_q <= '0;
        else if (wr)     out_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                     in_q <= '0;
        else if (en && !dir && fall) in_q <= pin_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bf   <= 1'b0;
            intr <= 1'b0;
        end else if (init) begin
            bf   <= 1'b0;
            intr <= dir;
        end else if (!dir) begin
            if (fall)       bf   <= 1'b1;
            if (rise && ie) intr <= 1'b1;
            if (rd) begin
                bf   <= 1'b0;
                intr <= 1'b0;
            end
        end else begin
            if (fall)       bf   <= 1'b0;
            if (rise && ie) intr <= 1'b1;
            if (wr) begin
                bf   <= 1'b1;
                intr <= 1'b0;
            end
        end
    end

    assign rdata = dir ? out_q : (en ? in_q : pin_in);

    // R3
    in_mode_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !dir |=> (!dir -> out_q == '0));

    // R4
    same_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && dir && (wdata == out_q)) |=> $stable(out_q));

    // R7
    group_init_chk: assert property (@(posedge clk) disable iff (rst)
        init |=> (!bf && (intr == $past(dir))));

    // R8
    in_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !dir && rd && !init) |=> (!bf && !intr));

    // R9
    out_write_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir && wr && !init) |=> (bf && !intr));

endmodule

// File: rtl/hsk_ports.sv
module hsk_ports
    import hsk_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_dir_a,
    input  logic          cmd_dir_b,
    input  logic [1:0]    cmd_pc_mode,
    input  logic          cmd_ie_a,
    input  logic          cmd_ie_b,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_sel,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic          pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [CW-1:0] pc_in,
    output logic [CW-1:0] pc_out,
    output logic [CW-1:0] pc_oe,
    output logic [5:0]    stat
);
    localparam int STB_A = 2;
    localparam int STB_B = 5;

    pc_mode_e  mode;
    port_sel_e sel;
    logic en_a, en_b;
    logic [PW-1:0] rd_a, rd_b;
    logic bf_a, intr_a, bf_b, intr_b;
    logic [CW-1:0] pc_q, pc_rd;
    stat_t st;

    assign mode = pc_mode_e'(cmd_pc_mode);
    assign sel  = port_sel_e'(bus_sel);
    assign en_a = grp_a_on(mode);
    assign en_b = grp_b_on(mode);

    hsk_port #(.W(PW)) u_port_a (
        .clk(clk), .rst(rst), .en(en_a), .dir(cmd_dir_a), .ie(cmd_ie_a),
        .wr(bus_wr && sel == SEL_A), .rd(bus_rd && sel == SEL_A),
        .wdata(bus_wdata), .pin_in(pa_in), .stb_n(pc_in[STB_A]),
        .out_q(pa_out), .rdata(rd_a), .bf(bf_a), .intr(intr_a)
    );

    hsk_port #(.W(PW)) u_port_b (
        .clk(clk), .rst(rst), .en(en_b), .dir(cmd_dir_b), .ie(cmd_ie_b),
        .wr(bus_wr && sel == SEL_B), .rd(bus_rd && sel == SEL_B),
        .wdata(bus_wdata), .pin_in(pb_in), .stb_n(pc_in[STB_B]),
        .out_q(pb_out), .rdata(rd_b), .bf(bf_b), .intr(intr_b)
    );

    assign pa_oe = cmd_dir_a;
    assign pb_oe = cmd_dir_b;

    always_ff @(posedge clk) begin
        if (rst || mode == PC_ALL_IN || mode == PC_AB_CTL) pc_q <= '0;
        else if (bus_wr && sel == SEL_C)                     pc_q <= bus_wdata[CW-1:0];
    end

    always_comb begin
        case (mode)
            PC_ALL_IN: begin
                pc_out = '0;
                pc_rd  = pc_in;
            end
            PC_A_CTL: begin
                pc_out = {pc_q[5:3], 1'b0, bf_a, intr_a};
                pc_rd  = {pc_q[5:3], pc_in[STB_A], bf_a, intr_a};
            end
            PC_AB_CTL: begin
                pc_out = {1'b0, bf_b, intr_b, 1'b0, bf_a, intr_a};
                pc_rd  = {pc_in[STB_B], bf_b, intr_b, pc_in[STB_A], bf_a, intr_a};
            end
            default: begin
                pc_out = pc_q;
                pc_rd  = pc_q;
            end
        endcase
    end

    assign pc_oe = pc_oe_map(mode);

    always_comb begin
        case (sel)
            SEL_A:   bus_rdata = rd_a;
            SEL_B:   bus_rdata = rd_b;
            SEL_C:   bus_rdata = {{(PW-CW){1'b0}}, pc_rd};
            default: bus_rdata = '0;
        endcase
    end

    always_comb begin
        st.intr_a = intr_a;
        st.bf_a   = bf_a;
        st.ie_a   = cmd_ie_a;
        st.intr_b = intr_b;
        st.bf_b   = bf_b;
        st.ie_b   = cmd_ie_b;
    end
    assign stat = st;

    // R10
    b_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_b |=> (!en_b -> stat[4:3] == 2'b00));

    // R10
    a_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en_a |=> (!en_a -> stat[1:0] == 2'b00));

    // R3
    pc_in_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == PC_ALL_IN) |=> ((mode == PC_ALL_OUT) -> pc_out == '0));

endmodule

// File: tb/hsk_ports_tb.sv
module hsk_ports_tb;

    logic       clk = 0;
    logic       rst = 1;
    logic       dir_a = 0, dir_b = 0, ie_a = 0, ie_b = 0;
    logic [1:0] pcm = 0;
    logic       wr = 0, rd = 0;
    logic [1:0] sel = 3;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [7:0] pa_in = 0, pb_in = 0, pa_out, pb_out;
    logic       pa_oe, pb_oe;
    logic [5:0] pc_in = 6'h3F, pc_out, pc_oe, stat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hsk_ports u_dut (
        .clk(clk), .rst(rst), .cmd_dir_a(dir_a), .cmd_dir_b(dir_b),
        .cmd_pc_mode(pcm), .cmd_ie_a(ie_a), .cmd_ie_b(ie_b),
        .bus_wr(wr), .bus_rd(rd), .bus_sel(sel), .bus_wdata(wdata),
        .bus_rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
        .pc_out(pc_out), .pc_oe(pc_oe), .stat(stat)
    );

    // {pc_mode[1:0], dir, sel[1:0], wdata[7:0], pins[7:0], expected[7:0]}
    localparam logic [28:0] VEC [8] = '{
        {2'b00, 1'b1, 2'd0, 8'hA5, 8'h3C, 8'hA5},
        {2'b00, 1'b0, 2'd0, 8'hFF, 8'h3C, 8'h3C},
        {2'b00, 1'b1, 2'd1, 8'h5A, 8'hC3, 8'h5A},
        {2'b00, 1'b0, 2'd1, 8'h77, 8'hC3, 8'hC3},
        {2'b11, 1'b0, 2'd2, 8'h2A, 8'h15, 8'h2A},
        {2'b00, 1'b0, 2'd2, 8'h3F, 8'h15, 8'h15},
        {2'b01, 1'b0, 2'd2, 8'h38, 8'h04, 8'h3C},
        {2'b10, 1'b1, 2'd2, 8'h12, 8'h24, 8'h2D}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic do_rd(input string req, input logic [1:0] s, input logic [7:0] exp);
        @(negedge clk);
        sel = s;
        #1;
        chk(req, rdata, exp);
        rd = 1;
        @(negedge clk);
        rd = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 stat", {2'b00, stat}, 8'h00);

        // R2 R5 table walk
        for (int i = 0; i < 8; i++) begin
            logic [28:0] v;
            v = VEC[i];
            pcm = v[28:27]; dir_a = v[26]; dir_b = v[26];
            pa_in = v[15:8]; pb_in = v[15:8]; pc_in = v[13:8];
            cyc(3);
            do_wr(v[25:24], v[23:16]);
            cyc(1);
            do_rd($sformatf("R2 R5 vector %0d", i), v[25:24], v[7:0]);
        end

        // R5 port C enables per mode
        pcm = 2'b00; dir_a = 0; dir_b = 0; pc_in = 6'h3F; cyc(2);
        chk("R5 oe mode00", {2'b00, pc_oe}, 8'h00);
        pcm = 2'b01; cyc(1);
        chk("R5 oe mode01", {2'b00, pc_oe}, 8'h3B);
        pcm = 2'b10; cyc(1);
        chk("R5 oe mode10", {2'b00, pc_oe}, 8'h1B);
        pcm = 2'b11; cyc(1);
        chk("R5 oe mode11", {2'b00, pc_oe}, 8'h3F);

        // R3 R4 latch behaviour on port A
        pcm = 2'b00; dir_a = 1; cyc(2);
        do_wr(2'd0, 8'hFF);
        do_wr(2'd0, 8'hFF);
        chk("R4 rewrite same value", pa_out, 8'hFF);
        dir_a = 0; cyc(2);
        chk("R3 input clears", {pa_oe, 7'd0} | pa_out, 8'h00);
        do_wr(2'd0, 8'h55);
        dir_a = 1; cyc(1);
        chk("R3 output after input", pa_out, 8'h00);

        // R7 R8 strobed input on A, R9 output on B
        pcm = 2'b10; dir_a = 0; dir_b = 1; ie_a = 1; ie_b = 1;
        pc_in = 6'h3F; cyc(4);
        chk("R7 input group init", {6'd0, stat[1:0]}, 8'h00);
        chk("R7 output group init", {6'd0, stat[4:3]}, 8'h01);
        chk("R10 enable bits", {6'd0, stat[5], stat[2]}, 8'h03);
        pa_in = 8'h9E; pc_in = 6'h3B; cyc(5);
        chk("R8 bf on strobe fall", {6'd0, stat[1:0]}, 8'h02);
        pa_in = 8'h11; pc_in = 6'h3F; cyc(5);
        chk("R8 intr on strobe end", {6'd0, stat[1:0]}, 8'h03);
        do_rd("R8 latched data", 2'd0, 8'h9E);
        chk("R8 read clears", {6'd0, stat[1:0]}, 8'h00);
        cyc(10);
        chk("R11 single event", {6'd0, stat[1:0]}, 8'h00);

        do_wr(2'd1, 8'h66);
        chk("R9 write sets bf", {6'd0, stat[4:3]}, 8'h02);
        chk("R9 port drives", pb_out, 8'h66);
        chk("R6 pc bf_b pin", {7'd0, pc_out[4]}, 8'h01);
        pc_in = 6'h1F; cyc(5);
        chk("R9 strobe clears bf", {6'd0, stat[4:3]}, 8'h00);
        pc_in = 6'h3F; cyc(5);
        chk("R9 intr on strobe end", {6'd0, stat[4:3]}, 8'h01);
        chk("R6 pc intr_b pin", {7'd0, pc_out[3]}, 8'h01);

        // R8 interrupt disabled
        ie_a = 0; pc_in = 6'h3B; cyc(5);
        pc_in = 6'h3F; cyc(5);
        chk("R8 no intr when disabled", {6'd0, stat[1:0]}, 8'h02);

        // R10 B group off in mode 01
        pcm = 2'b01; cyc(2);
        chk("R10 B flags off", {6'd0, stat[4:3]}, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule